// File: doc/BRIEF.md
# Indirect Read Buffer Engine

This block collects a programmed number of bytes from a flash read path and stores them in a small internal FIFO that is one 32-bit word wide. A host then empties the FIFO through a pop port. The flash side is a plain byte stream with a valid/ready handshake. The engine packs the incoming bytes into words, and it holds the source back with `src_ready` whenever the FIFO has no room. Once every requested byte is inside the FIFO, the engine raises a sticky done flag and a completion event.

The host controls the engine through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational from `reg_rd_addr`. The register set is:
- a control word with start, cancel and done bits;
- the flash start address, which is passed straight to the flash side;
- the transfer length in bytes;
- a watermark in bytes;
- a read-only fill level in words;
- an interrupt status register, cleared by writing 1 to a bit;
- an interrupt mask register.

Three events are recorded in the status register: completion, a watermark crossing, and an overflow when a byte is offered while the FIFO is full. The `irq` output is high whenever any status bit is set together with its mask bit.

Top module: `rdbuf_engine`

## Requirements
- R1: After reset the engine is idle, the FIFO is empty, every register reads zero, and `src_ready`, `fl_busy`, `pop_valid` and `irq` are low.
- R2: Writing the control word (register 0) with bit 0 set while the engine is idle does three things. It loads the byte count from register 2, raises `fl_busy`, and enables the source. `src_ready` is high only while the engine is busy, bytes remain to be taken, and the FIFO is not full. `fl_addr` always shows register 1.
- R3: Bytes are packed little-endian. The first byte of each group of four goes to word bits 7:0 and the fourth to bits 31:24. The packed word enters the FIFO on the clock edge that accepts its last byte. `pop_data` shows the oldest word while `pop_valid` is high. `pop_req` removes that word.
- R4: When the byte count is not a multiple of four, the final word holds the remaining 1 to 3 bytes in its lowest byte lanes, and its unused upper lanes are zero.
- R5: Register 4 reads the number of filled FIFO words in bits 15:0. That number never exceeds the FIFO depth.
- R6: In the cycle after the last byte is accepted, the engine goes idle. At the same time it sets the done flag (register 0, bit 5) and sets status bit 2. Writing 1 to control bit 5 clears the done flag, and a new start also clears it.
- R7: Status bit 6 is set when the fill level in bytes (words × 4) moves from below the watermark (register 3) to at or above it.
- R8: Status bit 12 is set when the source offers a byte while the engine is busy, bytes remain to be taken, and the FIFO is full. That byte is not accepted, so no byte is lost.
- R9: Writing control bit 1 cancels the transfer. It empties the FIFO, returns the engine to idle, and does not set the done flag or status bit 2. If start and cancel are written together, cancel wins.
- R10: Writing 1 to a bit of the status register (register 5) clears that bit. If a new event arrives in the same cycle, the set wins. `irq` is the OR of status ANDed with the mask (register 6).
- R11: A start written while a transfer is running is ignored. The running transfer keeps its original byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| src_valid | input | 1 | Flash byte valid |
| src_data | input | 8 | Flash byte |
| src_ready | output | 1 | Engine accepts a flash byte |
| fl_addr | output | 32 | Programmed flash start address |
| fl_busy | output | 1 | Transfer in progress |
| pop_req | input | 1 | Host removes the head word |
| pop_valid | output | 1 | FIFO holds at least one word |
| pop_data | output | 32 | Head word of the FIFO |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check the following on every cycle:
- `src_ready` is never high unless the engine is busy, and it is always low when the FIFO is full.
- The fill level stays within the FIFO depth.
- A cancel always leaves the engine idle and empty, and never produces a done flag.
- `irq` is never high with an all-zero mask.
- The done flag rises only at the end of a busy period.

Some behaviours depend on data and event history, and only the bench's scenarios can show them:
- little-endian byte packing and the zero-filled partial last word;
- the exact status bits produced by a watermark crossing and by a stalled overflow;
- the write-one-to-clear behaviour;
- a second start being ignored;
- a zero-length transfer completing at once.

The bench compares these against its reference model.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
    localparam int BYTES_PER_WORD = 4;
    localparam int STAT_W         = 16;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_ADDR  = 3'd1;
    localparam logic [2:0] A_COUNT = 3'd2;
    localparam logic [2:0] A_WMARK = 3'd3;
    localparam logic [2:0] A_LEVEL = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;
    localparam logic [2:0] A_MASK  = 3'd6;

    localparam int CTRL_START = 0;
    localparam int CTRL_CANCEL = 1;
    localparam int CTRL_DONE  = 5;

    localparam int EV_DONE = 2;
    localparam int EV_WM   = 6;
    localparam int EV_OVF  = 12;
endpackage

// File: rtl/rdbuf_fifo.sv
module rdbuf_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t         s_d, s_q;
    logic [W-1:0]  mem [DEPTH];
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        push_ok = push && (s_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (s_q.cnt != '0);
        if (push_ok) s_d.wp = step(s_q.wp);
        if (pop_ok)  s_d.rp = step(s_q.rp);
        s_d.cnt = s_q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (flush) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[s_q.wp] <= push_data;
    end

    assign head  = mem[s_q.rp];
    assign count = s_q.cnt;
endmodule

// File: rtl/rdbuf_irq.sv
module rdbuf_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic         clr_en,
    input  logic         mask_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] mask;
    } irq_t;

    irq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_en)  r_d.status = r_q.status & ~wdata;
        r_d.status = r_d.status | set_ev;
        if (mask_en) r_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = r_q.status;
    assign mask   = r_q.mask;
    assign irq_o  = |(r_q.status & r_q.mask);
endmodule

// File: rtl/rdbuf_engine.sv
module rdbuf_engine
    import rdbuf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int WM_W   = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rdata,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_busy,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [31:0]       pop_data,
    output logic              irq
);
    localparam int WORD_W = BYTES_PER_WORD * 8;
    localparam int LVL_W  = $clog2(DEPTH+1);
    localparam int LANE_W = $clog2(BYTES_PER_WORD);
    localparam int BLV_W  = LVL_W + LANE_W;
    localparam int CMP_W  = ((WM_W > BLV_W) ? WM_W : BLV_W) + 1;

    typedef struct packed {
        logic              active;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  rem;
        logic [WM_W-1:0]   wm;
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] asm_w;
    } eng_t;

    eng_t               q, d;
    logic [LVL_W-1:0]   fifo_words;
    logic [WORD_W-1:0]  fifo_head, merged;
    logic [STAT_W-1:0]  irq_status, irq_mask, ev_set;
    logic               wr_ctrl, start_w, cancel_w, done_clr;
    logic               has_work, fifo_full, accept, ovf_ev, push, pop, finish, wm_ev;
    logic [CMP_W-1:0]   lvl_now, lvl_next, words_next;
    logic               done_flag;

    always_comb begin
        d         = q;
        wr_ctrl   = reg_wr_en && (reg_wr_addr == A_CTRL);
        start_w   = wr_ctrl && reg_wdata[CTRL_START];
        cancel_w  = wr_ctrl && reg_wdata[CTRL_CANCEL];
        done_clr  = wr_ctrl && reg_wdata[CTRL_DONE];
        fifo_full = (fifo_words == LVL_W'(DEPTH));
        has_work  = q.active && (q.rem != '0);
        accept    = src_valid && has_work && !fifo_full;
        ovf_ev    = src_valid && has_work && fifo_full;
        merged    = q.asm_w | (WORD_W'(src_data) << {q.lane, 3'b000});
        push      = accept && ((q.lane == LANE_W'(BYTES_PER_WORD-1)) || (q.rem == CNT_W'(1)));
        pop       = pop_req && (fifo_words != '0);
        finish    = q.active && (q.rem == '0) && !cancel_w;

        if (accept) begin
            d.rem = q.rem - 1'b1;
            if (push) begin
                d.lane  = '0;
                d.asm_w = '0;
            end else begin
                d.lane  = q.lane + 1'b1;
                d.asm_w = merged;
            end
        end
        if (done_clr) d.done = 1'b0;
        if (finish) begin
            d.active = 1'b0;
            d.done   = 1'b1;
        end
        if (start_w && !q.active && !cancel_w) begin
            d.active = 1'b1;
            d.rem    = q.count;
            d.lane   = '0;
            d.asm_w  = '0;
            d.done   = 1'b0;
        end
        if (cancel_w) begin
            d.active = 1'b0;
            d.rem    = '0;
            d.lane   = '0;
            d.asm_w  = '0;
        end
        if (reg_wr_en) begin
            case (reg_wr_addr)
                A_ADDR:  d.addr  = reg_wdata[ADDR_W-1:0];
                A_COUNT: d.count = reg_wdata[CNT_W-1:0];
                A_WMARK: d.wm    = reg_wdata[WM_W-1:0];
                default: ;
            endcase
        end

        words_next = cancel_w ? '0
                   : CMP_W'(fifo_words) + CMP_W'(push) - CMP_W'(pop);
        lvl_now    = CMP_W'(fifo_words) << LANE_W;
        lvl_next   = words_next << LANE_W;
        wm_ev      = (lvl_now < CMP_W'(q.wm)) && (lvl_next >= CMP_W'(q.wm));

        ev_set          = '0;
        ev_set[EV_DONE] = finish;
        ev_set[EV_WM]   = wm_ev;
        ev_set[EV_OVF]  = ovf_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rdbuf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cancel_w),
        .push      (push),
        .push_data (merged),
        .pop       (pop),
        .head      (fifo_head),
        .count     (fifo_words)
    );

    rdbuf_irq #(.W(STAT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (ev_set),
        .clr_en  (reg_wr_en && (reg_wr_addr == A_STAT)),
        .mask_en (reg_wr_en && (reg_wr_addr == A_MASK)),
        .wdata   (reg_wdata[STAT_W-1:0]),
        .status  (irq_status),
        .mask    (irq_mask),
        .irq_o   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_rd_addr)
            A_CTRL:  reg_rdata[CTRL_DONE] = q.done;
            A_ADDR:  reg_rdata = 32'(q.addr);
            A_COUNT: reg_rdata = 32'(q.count);
            A_WMARK: reg_rdata = 32'(q.wm);
            A_LEVEL: reg_rdata = 32'(fifo_words);
            A_STAT:  reg_rdata = 32'(irq_status);
            A_MASK:  reg_rdata = 32'(irq_mask);
            default: reg_rdata = '0;
        endcase
    end

    assign done_flag = q.done;
    assign src_ready = has_work && !fifo_full;
    assign fl_busy   = q.active;
    assign fl_addr   = q.addr;
    assign pop_valid = (fifo_words != '0);
    assign pop_data  = fifo_head;
endmodule

// File: rtl/rdbuf_checker.sv
module rdbuf_checker #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       src_ready,
    input logic                       fl_busy,
    input logic [$clog2(DEPTH+1)-1:0] fifo_words,
    input logic                       irq,
    input logic [15:0]                irq_mask,
    input logic                       done_flag,
    input logic                       cancel_wr
);
    p_ready_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> fl_busy);

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_words) <= DEPTH);

    p_stall_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_words) == DEPTH) |-> !src_ready);

    p_cancel_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_wr |=> (!fl_busy && fifo_words == '0));

    p_cancel_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_wr && !done_flag) |=> !done_flag);

    p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask != '0));

    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(fl_busy));
endmodule

bind rdbuf_engine rdbuf_checker #(.DEPTH(DEPTH)) u_rdbuf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_ready  (src_ready),
    .fl_busy    (fl_busy),
    .fifo_words (fifo_words),
    .irq        (irq),
    .irq_mask   (irq_mask),
    .done_flag  (done_flag),
    .cancel_wr  (cancel_w)
);

// File: tb/rdbuf_engine_bench.sv
`timescale 1ns/1ps
module rdbuf_engine_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rdata;
    logic        src_valid = 1'b0;
    logic [7:0]  src_data;
    logic        src_ready;
    logic [31:0] fl_addr;
    logic        fl_busy;
    logic        pop_req = 1'b0;
    logic        pop_valid;
    logic [31:0] pop_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int byte_ctr = 0;

    always #2 clk = ~clk;

    assign src_data = byte_ctr[7:0];

    rdbuf_engine u_rdbuf_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .fl_addr(fl_addr), .fl_busy(fl_busy),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] mq[$];
    bit          m_active, m_done;
    int          m_rem, m_lane;
    logic [31:0] m_asm, m_addr;
    logic [15:0] m_cnt, m_wm, m_stat, m_mask;

    function automatic logic [31:0] m_rdata(input logic [2:0] a);
        case (a)
            3'd0: m_rdata = {26'b0, m_done, 5'b0};
            3'd1: m_rdata = m_addr;
            3'd2: m_rdata = {16'b0, m_cnt};
            3'd3: m_rdata = {16'b0, m_wm};
            3'd4: m_rdata = mq.size();
            3'd5: m_rdata = {16'b0, m_stat};
            3'd6: m_rdata = {16'b0, m_mask};
            default: m_rdata = 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq.delete();
            m_active = 0; m_done = 0; m_rem = 0; m_lane = 0;
            m_asm = 0; m_addr = 0; m_cnt = 0; m_wm = 0; m_stat = 0; m_mask = 0;
        end else begin
            bit full, acc, ovf, popd, push, st, cn, dc, cmp, act0;
            int rem0, old_b, new_b;
            logic [31:0] w;
            logic [15:0] set, clr;
            full = (mq.size() == DEPTH);
            acc  = src_valid && m_active && m_rem != 0 && !full;
            ovf  = src_valid && m_active && m_rem != 0 && full;
            popd = pop_req && mq.size() != 0;
            st   = reg_wr_en && reg_wr_addr == 3'd0 && reg_wdata[0];
            cn   = reg_wr_en && reg_wr_addr == 3'd0 && reg_wdata[1];
            dc   = reg_wr_en && reg_wr_addr == 3'd0 && reg_wdata[5];
            act0 = m_active; rem0 = m_rem;
            old_b = mq.size() * 4;
            set = 0; push = 0;
            w = m_asm | (32'(src_data) << (8 * m_lane));
            if (acc) begin
                push = (m_lane == 3) || (rem0 == 1);
                m_rem = m_rem - 1;
                if (push) begin m_lane = 0; m_asm = 0; end
                else begin m_lane = m_lane + 1; m_asm = w; end
                byte_ctr <= byte_ctr + 1;
            end
            if (popd) void'(mq.pop_front());
            if (push) mq.push_back(w);
            cmp = act0 && rem0 == 0 && !cn;
            if (dc) m_done = 0;
            if (cmp) begin m_done = 1; m_active = 0; set[2] = 1'b1; end
            if (st && !act0 && !cn) begin
                m_active = 1; m_rem = m_cnt; m_lane = 0; m_asm = 0; m_done = 0;
            end
            if (cn) begin mq.delete(); m_active = 0; m_rem = 0; m_lane = 0; m_asm = 0; end
            if (ovf) set[12] = 1'b1;
            new_b = mq.size() * 4;
            if (old_b < int'(m_wm) && new_b >= int'(m_wm)) set[6] = 1'b1;
            clr = (reg_wr_en && reg_wr_addr == 3'd5) ? reg_wdata[15:0] : 16'h0;
            m_stat = (m_stat & ~clr) | set;
            if (reg_wr_en) begin
                case (reg_wr_addr)
                    3'd1: m_addr = reg_wdata;
                    3'd2: m_cnt  = reg_wdata[15:0];
                    3'd3: m_wm   = reg_wdata[15:0];
                    3'd6: m_mask = reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion before 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check("R2 src_ready", 32'(src_ready), 32'(m_active && m_rem != 0 && mq.size() != DEPTH));
            check("R2 fl_busy", 32'(fl_busy), 32'(m_active));
            check("R2 fl_addr", fl_addr, m_addr);
            check("R5 pop_valid", 32'(pop_valid), 32'(mq.size() != 0));
            if (mq.size() != 0) check("R3 pop_data", pop_data, mq[0]);
            check("R10 irq", 32'(irq), 32'(|(m_stat & m_mask)));
            check("R5 reg_rdata", reg_rdata, m_rdata(reg_rd_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] dat);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wdata = dat;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_n(input int n);
        @(negedge clk);
        pop_req = 1'b1;
        repeat (n) @(negedge clk);
        pop_req = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        #1;
        check("R1 src_ready", 32'(src_ready), 0);
        check("R1 fl_busy", 32'(fl_busy), 0);
        check("R1 pop_valid", 32'(pop_valid), 0);
        check("R1 irq", 32'(irq), 0);
        rchk("R1 ctrl", 3'd0, 0);
        rchk("R1 level", 3'd4, 0);
        rchk("R1 status", 3'd5, 0);

        // Scenario A: 10 bytes, partial final word
        src_valid = 1'b1;
        idle(2);
        #1 check("R2 idle no ready", 32'(src_ready), 0);
        wr(3'd1, 32'h1234_5678);
        #1 check("R2 fl_addr", fl_addr, 32'h1234_5678);
        wr(3'd3, 8);
        wr(3'd2, 10);
        wr(3'd6, 32'h1044);
        wr(3'd0, 1);
        #1 check("R2 ready after start", 32'(src_ready), 1);
        idle(20);
        rchk("R6 done set", 3'd0, 32'h20);
        rchk("R5 level words", 3'd4, 3);
        rchk("R7 status wm+done", 3'd5, 32'h44);
        check("R10 irq high", 32'(irq), 1);
        check("R3 first word", pop_data, 32'h0302_0100);
        pop_n(2);
        #1 check("R4 partial word", pop_data, 32'h0000_0908);
        pop_n(1);
        rchk("R5 level empty", 3'd4, 0);
        wr(3'd5, 32'h44);
        rchk("R10 status cleared", 3'd5, 0);
        check("R10 irq low", 32'(irq), 0);
        wr(3'd0, 32'h20);
        rchk("R6 done cleared", 3'd0, 0);

        // Scenario B: fill to full, stall and overflow
        byte_ctr = 0;
        wr(3'd3, 16);
        wr(3'd2, 40);
        wr(3'd0, 1);
        idle(45);
        #1 check("R8 stalled", 32'(src_ready), 0);
        check("R8 still busy", 32'(fl_busy), 1);
        rchk("R5 level full", 3'd4, DEPTH);
        rchk("R8 overflow+wm", 3'd5, 32'h1040);
        wr(3'd5, 32'hFFFF);
        pop_req = 1'b1;
        idle(30);
        pop_req = 1'b0;
        rchk("R6 done after drain", 3'd0, 32'h20);
        rchk("R5 level drained", 3'd4, 0);
        check("R8 no byte lost", 32'(byte_ctr), 40);
        wr(3'd5, 32'hFFFF);
        wr(3'd0, 32'h20);

        // Scenario C: cancel mid-transfer
        byte_ctr = 0;
        wr(3'd2, 20);
        wr(3'd0, 1);
        idle(5);
        wr(3'd0, 2);
        #1 check("R9 idle after cancel", 32'(fl_busy), 0);
        check("R9 no ready", 32'(src_ready), 0);
        rchk("R9 level flushed", 3'd4, 0);
        rchk("R9 no done", 3'd0, 0);
        rchk("R9 no completion", 3'd5, 0);

        // Scenario D: start while active ignored
        byte_ctr = 0;
        wr(3'd2, 12);
        wr(3'd0, 1);
        wr(3'd2, 100);
        wr(3'd0, 1);
        idle(20);
        check("R11 original count", 32'(byte_ctr), 12);
        rchk("R11 level", 3'd4, 3);
        rchk("R6 done D", 3'd0, 32'h20);
        pop_n(3);
        wr(3'd0, 32'h20);
        wr(3'd5, 32'hFFFF);

        // Scenario E: zero-length transfer
        wr(3'd2, 0);
        wr(3'd0, 1);
        idle(2);
        rchk("R6 zero length done", 3'd0, 32'h20);
        check("R6 zero length idle", 32'(fl_busy), 0);
        src_valid = 1'b0;
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule